// File: doc/BRIEF.md
# Frame alignment character inserter

This block sits on the transmit side of a JESD204A-style serial link for a 14-bit converter, ahead of the 8b/10b encoder. It turns each accepted sample into a frame of two octets, high octet first, and puts out one octet per clock. It also marks the octet that closes each frame and the octet that closes each multiframe.

Only the closing octet of a frame can be swapped for a control character. The swap condition depends on the scrambling setting. With scrambling off, the closing octet is swapped when it repeats the closing octet of the previous frame. With scrambling on, it is swapped when it carries the data value 0xFC.

The control character depends on the lane synchronization setting. With synchronization on, a frame that closes a multiframe gets 0x7C and any other frame gets 0xFC. With synchronization off, every swap uses 0xFC. The receiver uses these characters to confirm that it is still aligned to frames and multiframes.

Top module: `fa_char_inserter`

## Requirements
- R1: While reset is active and after its release, with no accepted sample, `oct_vld_o`, `ctrl_o`, `fend_o` and `mfend_o` are 0.
- R2: A sample accepted at a clock edge appears as its high octet `sample_i[13:6]` in the next cycle and as its low octet `{sample_i[5:0],2'b00}` in the cycle after that. `fend_o` is 1 only on the low octet.
- R3: A `valid_i` pulse in a cycle where a high octet is on the output is ignored and produces no output octet. A sample can be accepted every second cycle.
- R4: With `scramble_en_i`=0, the low octet is replaced when it equals the original low octet of the previous frame. The first frame after reset is never replaced.
- R5: With `scramble_en_i`=1, the low octet is replaced exactly when it equals 0xFC, whatever the previous frame held.
- R6: A high octet is never replaced and always has `ctrl_o`=0, even when it equals 0xFC or the previous frame's octet.
- R7: With `lane_sync_en_i`=1, a replaced octet is 0x7C when it closes a multiframe and 0xFC otherwise.
- R8: With `lane_sync_en_i`=0, a replaced octet is always 0xFC, including at a multiframe end.
- R9: Counting from reset, `mfend_o` is 1 on the low octet of every MF_FRAMES-th frame (default 4) and 0 on all other octets.
- R10: The previous-frame comparison uses the unreplaced value, so a run of identical frames is replaced on every frame after the first.
- R11: `ctrl_o` is 1 only on a replaced octet. Every other octet passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Converter sample |
| valid_i | input | 1 | Sample strobe |
| scramble_en_i | input | 1 | Static setting: scrambling enabled |
| lane_sync_en_i | input | 1 | Static setting: lane synchronization enabled |
| oct_o | output | 8 | Output octet |
| oct_vld_o | output | 1 | Output octet valid |
| ctrl_o | output | 1 | Octet is an inserted control character |
| fend_o | output | 1 | Octet closes a frame |
| mfend_o | output | 1 | Octet closes a multiframe |

## Verification
The high octet of a sample accepted at an edge is due one cycle later, and its possibly replaced low octet two cycles later, together with the frame and multiframe markers. The driver pushes both expected octets into a queue when it asserts `valid_i`, working out the replacement and the multiframe position with its own reference model. A monitor samples the outputs on every falling edge and compares them against the queue in order, so any missing, extra or early octet shows up as a mismatch. The static settings change only after the stream has drained, so that the combinational choice of character never races the sampling point.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam logic [7:0] CHAR_K28_7 = 8'hFC;
  localparam logic [7:0] CHAR_K28_3 = 8'h7C;
  localparam logic [7:0] DATA_D28_7 = 8'hFC;

  typedef struct packed {
    logic [7:0] data;
    logic       vld;
    logic       last;
  } raw_oct_t;
endpackage

// File: rtl/fa_frame_packer.sv
module fa_frame_packer #(
  parameter int SAMPLE_W = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SAMPLE_W-1:0]   sample_i,
  input  logic                  valid_i,
  output fa_pkg::raw_oct_t      raw_o
);
  localparam int PAD_W = 16 - SAMPLE_W;

  logic [15:0]      just;
  logic [7:0]       lsb_hold_q;
  fa_pkg::raw_oct_t raw_q;
  logic             msb_busy;

  assign just     = {sample_i, {PAD_W{1'b0}}};
  assign msb_busy = raw_q.vld && !raw_q.last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q      <= '0;
      lsb_hold_q <= '0;
    end else if (valid_i && !msb_busy) begin
      raw_q      <= '{data: just[15:8], vld: 1'b1, last: 1'b0};
      lsb_hold_q <= just[7:0];
    end else if (msb_busy) begin
      raw_q      <= '{data: lsb_hold_q, vld: 1'b1, last: 1'b1};
    end else begin
      raw_q      <= '0;
    end
  end

  assign raw_o = raw_q;

  p_lsb_follows_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q.vld && !raw_q.last) |=> (raw_q.vld && raw_q.last));
  p_lsb_has_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q.vld && raw_q.last) |-> $past(raw_q.vld && !raw_q.last));
endmodule

// File: rtl/fa_mframe_counter.sv
module fa_mframe_counter #(
  parameter int MF_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_done_i,
  output logic mf_last_o
);
  localparam int CNT_W = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;

  generate
    if (MF_FRAMES == 1) begin : g_single
      assign mf_last_o = 1'b1;
    end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_FRAMES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (frame_done_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign mf_last_o = (cnt_q == LAST);

      p_cnt_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
      p_cnt_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_done_i && mf_last_o) |=> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/fa_replace_unit.sv
module fa_replace_unit (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fa_pkg::raw_oct_t raw_i,
  input  logic             mf_last_i,
  input  logic             scramble_en_i,
  input  logic             lane_sync_en_i,
  output logic [7:0]       oct_o,
  output logic             oct_vld_o,
  output logic             ctrl_o,
  output logic             fend_o,
  output logic             mfend_o
);
  import fa_pkg::*;

  logic [7:0] prev_q;
  logic       prev_vld_q;
  logic       is_end, hit, mf_end;
  logic [7:0] rep_char;

  assign is_end   = raw_i.vld && raw_i.last;
  assign mf_end   = is_end && mf_last_i;
  assign hit      = is_end && (scramble_en_i ? (raw_i.data == DATA_D28_7)
                                             : (prev_vld_q && raw_i.data == prev_q));
  assign rep_char = (lane_sync_en_i && mf_end) ? CHAR_K28_3 : CHAR_K28_7;

  // keep the unreplaced value for the next comparison
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (is_end) begin
      prev_q     <= raw_i.data;
      prev_vld_q <= 1'b1;
    end
  end

  always_comb begin
    oct_vld_o = raw_i.vld;
    oct_o     = raw_i.vld ? (hit ? rep_char : raw_i.data) : 8'h00;
    ctrl_o    = hit;
    fend_o    = is_end;
    mfend_o   = mf_end;
  end

  p_msb_never_ctrl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oct_vld_o && !fend_o) |-> !ctrl_o);
  p_nosync_k28_7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o && !lane_sync_en_i) |-> (oct_o == CHAR_K28_7));
  p_k28_3_at_mf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o && oct_o == CHAR_K28_3) |-> (mfend_o && lane_sync_en_i));
  p_ctrl_only_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o |-> oct_vld_o);
endmodule

// File: rtl/fa_char_inserter.sv
module fa_char_inserter #(
  parameter int SAMPLE_W  = 14,
  parameter int MF_FRAMES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  input  logic                scramble_en_i,
  input  logic                lane_sync_en_i,
  output logic [7:0]          oct_o,
  output logic                oct_vld_o,
  output logic                ctrl_o,
  output logic                fend_o,
  output logic                mfend_o
);
  fa_pkg::raw_oct_t raw;
  logic             mf_last;

  fa_frame_packer #(.SAMPLE_W(SAMPLE_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .valid_i (valid_i),
    .raw_o   (raw)
  );

  fa_mframe_counter #(.MF_FRAMES(MF_FRAMES)) u_mf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_done_i(raw.vld && raw.last),
    .mf_last_o   (mf_last)
  );

  fa_replace_unit u_rep (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .raw_i         (raw),
    .mf_last_i     (mf_last),
    .scramble_en_i (scramble_en_i),
    .lane_sync_en_i(lane_sync_en_i),
    .oct_o         (oct_o),
    .oct_vld_o     (oct_vld_o),
    .ctrl_o        (ctrl_o),
    .fend_o        (fend_o),
    .mfend_o       (mfend_o)
  );

  p_mfend_on_fend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfend_o |-> fend_o);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oct_vld_o |-> (!ctrl_o && !fend_o && !mfend_o));
endmodule

// File: tb/fa_char_inserter_tb_top.sv
`timescale 1ns/1ps
module fa_char_inserter_tb_top;
  localparam int K = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] sample_i = '0;
  logic        valid_i = 1'b0;
  logic        scramble_en_i = 1'b0;
  logic        lane_sync_en_i = 1'b1;
  logic [7:0]  oct_o;
  logic        oct_vld_o, ctrl_o, fend_o, mfend_o;

  always #2.5 clk_i = ~clk_i;

  fa_char_inserter #(.SAMPLE_W(14), .MF_FRAMES(K)) dut_i (
    .clk_i, .rst_ni, .sample_i, .valid_i, .scramble_en_i, .lane_sync_en_i,
    .oct_o, .oct_vld_o, .ctrl_o, .fend_o, .mfend_o
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  m_prev = '0;
  bit          m_prev_vld = 0;
  int          m_fcnt = 0;
  bit          done = 0;

  function automatic logic [13:0] smp(logic [7:0] hi, logic [5:0] lo);
    return {hi, lo};
  endfunction

  // reference model: push both expected octets {data, ctrl, fend, mfend}
  task automatic push_frame(logic [13:0] s, string tag);
    logic [7:0] hi, lo, ch;
    bit mf, rep;
    hi  = s[13:6];
    lo  = {s[5:0], 2'b00};
    mf  = (m_fcnt == K - 1);
    rep = scramble_en_i ? (lo == 8'hFC) : (m_prev_vld && lo == m_prev);
    ch  = (lane_sync_en_i && mf) ? 8'h7C : 8'hFC;
    exp_q.push_back({hi, 1'b0, 1'b0, 1'b0});
    tag_q.push_back({tag, "/R2,R6"});
    exp_q.push_back({rep ? ch : lo, rep, 1'b1, mf});
    tag_q.push_back({tag, "/R2,R11"});
    m_prev = lo;
    m_prev_vld = 1;
    m_fcnt = mf ? 0 : m_fcnt + 1;
  endtask

  // driver: valid for one cycle; optional junk strobe during the high octet (R3)
  task automatic send(logic [13:0] s, string tag, bit junk = 0);
    @(negedge clk_i);
    sample_i = s;
    valid_i  = 1'b1;
    push_frame(s, tag);
    @(negedge clk_i);
    if (junk) begin
      sample_i = 14'h3FFF;
      valid_i  = 1'b1;
    end else begin
      valid_i  = 1'b0;
    end
  endtask

  task automatic drain_cfg(bit scr, bit ls);
    @(negedge clk_i); valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    scramble_en_i  = scr;
    lane_sync_en_i = ls;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && oct_vld_o) begin
        logic [10:0] act, e;
        string t;
        act = {oct_o, ctrl_o, fend_o, mfend_o};
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R3 unexpected octet act=%h exp=none", act);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (act !== e) begin
            n_bad++;
            $display("FAIL %s oct/ctrl/fend/mfend act=%h exp=%h", t, act, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during and after reset
    repeat (3) @(negedge clk_i);
    n_cmp++;
    if ({oct_vld_o, ctrl_o, fend_o, mfend_o} !== 4'b0) begin
      n_bad++;
      $display("FAIL R1 in reset act=%b exp=0000", {oct_vld_o, ctrl_o, fend_o, mfend_o});
    end
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    n_cmp++;
    if ({oct_vld_o, ctrl_o, fend_o, mfend_o} !== 4'b0) begin
      n_bad++;
      $display("FAIL R1 after reset act=%b exp=0000", {oct_vld_o, ctrl_o, fend_o, mfend_o});
    end

    // non-scrambled, lane sync on
    send(smp(8'h12, 6'h00), "R4 first frame not replaced");
    send(smp(8'h34, 6'h00), "R4 repeat replaced", 1);
    send(smp(8'h56, 6'h00), "R10 original compare");
    send(smp(8'h78, 6'h00), "R7 mframe end 7C", 1);
    send(smp(8'hFC, 6'h15), "R6 high FC kept");
    send(smp(8'hFC, 6'h3F), "R6 high repeat kept");
    send(smp(8'h9A, 6'h3F), "R4 repeat FC");
    send(smp(8'h01, 6'h2A), "R11 pass through");
    drain_cfg(1'b1, 1'b1);
    // scrambled, lane sync on
    send(smp(8'h11, 6'h2A), "R5 repeat not replaced");
    send(smp(8'h22, 6'h3F), "R5 FC replaced", 1);
    send(smp(8'h33, 6'h3F), "R5 FC again");
    send(smp(8'h44, 6'h3F), "R7 scrambled mframe end");
    send(smp(8'h55, 6'h1F), "R11 data 7C pass");
    send(smp(8'h66, 6'h1F), "R5 repeat 7C pass");
    drain_cfg(1'b1, 1'b0);
    // scrambled, lane sync off
    send(smp(8'h77, 6'h3F), "R8 FC");
    send(smp(8'h88, 6'h3F), "R8 mframe end stays FC");
    send(smp(8'h99, 6'h01), "R9 next multiframe");
    drain_cfg(1'b0, 1'b0);
    // non-scrambled, lane sync off
    send(smp(8'hAA, 6'h01), "R4 repeat across cfg");
    send(smp(8'hBB, 6'h05), "R9 no replace");
    send(smp(8'hCC, 6'h05), "R8 repeat at mframe end", 1);
    send(smp(8'hDD, 6'h05), "R10 run");
    drain_cfg(1'b0, 1'b1);
    for (int i = 0; i < 9; i++)
      send(smp(8'(i * 17), 6'(i)), "R9 counting");

    repeat (6) @(negedge clk_i);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing octets act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule